// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a synthesizable behavioural model of a parallel NOR flash device that follows the common JEDEC-style command protocol. It sits on a simple synchronous memory port with chip select, write enable, word address, write data and registered read data. The port fronts an internal array that is split into equal sectors of 16-bit words. An ordinary read returns array contents. Writes are not stored directly. Instead they are fed to a sequence tracker, which accepts the two unlock cycles at fixed word offsets and then a command cycle. That command selects word programming, erase, identification readout, the query table, or a bypass mode in which later commands need no unlock.

Programming clears bits only and completes in the cycle of the data write. Erases set a whole sector, or the whole array, back to all-ones at once. The device then stays busy for a parameterised number of clock cycles. While it is busy, reads return a status byte whose toggle bit flips on every read.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the device is in read-array mode, `busy` is low, and every array word reads 0xFFFF.
- R2: A command needs word address 0x555 with data 0xAA, then 0x2AA with data 0x55, then a command cycle at 0x555 whose low data byte is 0xA0 (program), 0x80 (erase setup), 0x90 (identification) or 0x20 (enter bypass). Any other write at one of these positions, including an unknown command byte, returns the device to read-array mode. Command bytes are compared on `wdata[7:0]`, and addresses are word addresses.
- R3: The write that follows a program command stores the bitwise AND of the old word and `wdata`, so it cannot set bits. The device then returns to read-array mode.
- R4: After erase setup, a second unlock pair and then 0x10 written at 0x555 sets every array word to 0xFFFF. `busy` rises after that write and stays high for exactly CHIP_ERASE_CYC clock cycles. A 0x10 at any other address aborts to read mode.
- R5: After erase setup, a second unlock pair and then 0x30 written at any address sets only the sector holding that address (address bits above the in-sector offset) to 0xFFFF. `busy` stays high for exactly SECTOR_ERASE_CYC cycles.
- R6: While `busy` is high, a read returns 0x0000 with bit 6 set to a toggle bit. The toggle bit is 0 on the first read after the erase starts and inverts after each read.
- R7: While `busy` is high every write is ignored, including 0xF0. When the erase ends, the device returns to read-array mode, or to the bypass command state if bypass was active.
- R8: Writing low byte 0xF0 returns the device to read-array mode and leaves bypass from any state except the erase busy interval and the program data cycle. In the program data cycle the value is programmed as data.
- R9: In identification mode, reads at address 0, 1, 2, 0x0E and 0x0F return MFR_ID, DEV_ID, 0x0000, EXT_ID0 and EXT_ID1. Every other address returns array data.
- R10: Writing 0x98 at address 0x55, in read-array or identification mode, enters query mode. There a read at address a returns table byte a, zero-extended, with 0x10..0x12 = 0x51, 0x52, 0x59; 0x13 = 0x02; 0x27 = log2 of array bytes; 0x2D = sectors-1; 0x2F = sector bytes/256. Addresses of 0x31 and above return 0. Any write leaves query mode.
- R11: After 0x20 the device is in bypass. In bypass, a command cycle at any address needs no unlock: 0xA0 and then a data write programs, and 0x80 starts erase setup. 0x90 followed by 0x00 leaves bypass to read-array mode. Array reads work in bypass.
- R12: `rdata` is updated at the clock edge that samples a read (cs high, we low) and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access strobe for this cycle |
| we | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data / command byte in bits 7:0 |
| rdata | output | 16 | Registered read data |
| busy | output | 1 | High during an erase interval |

## Verification
The results of a write are due at the edge that samples it: programmed words, mode changes and the start of `busy` are all visible at the next falling edge. Read data is due one edge after the read is sampled. The bench drives every access on a falling edge and samples `rdata` or `busy` on the following falling edge. A free-running edge counter, latched when an erase command write completes, measures the `busy` interval. The count is compared against the parameter exactly, even when status reads and ignored writes are interleaved.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [3:0] {
      ST_READ,
      ST_UNLK1,
      ST_CMD,
      ST_PROG,
      ST_ESET,
      ST_ESET1,
      ST_ESET2,
      ST_ERASE,
      ST_AUTO,
      ST_QUERY
   } seq_mode_e;

   localparam logic [7:0] CB_UNLOCK_A = 8'hAA;
   localparam logic [7:0] CB_UNLOCK_B = 8'h55;
   localparam logic [7:0] CB_PROGRAM  = 8'hA0;
   localparam logic [7:0] CB_ESETUP   = 8'h80;
   localparam logic [7:0] CB_IDENT    = 8'h90;
   localparam logic [7:0] CB_BYPASS   = 8'h20;
   localparam logic [7:0] CB_RESET    = 8'hF0;
   localparam logic [7:0] CB_QUERY    = 8'h98;
   localparam logic [7:0] CB_CHIP     = 8'h10;
   localparam logic [7:0] CB_SECTOR   = 8'h30;

   localparam int unsigned OFS_FIRST  = 'h555;
   localparam int unsigned OFS_SECOND = 'h2AA;
   localparam int unsigned OFS_QUERY  = 'h55;
   localparam int unsigned CMD_AW     = 11;
   localparam int unsigned QUERY_LEN  = 'h31;

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        cmd,
   input  logic              erase_done,
   output seq_mode_e         mode,
   output logic              bypass,
   output logic              prog_en,
   output logic              esec_en,
   output logic              echip_en
);

   localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(OFS_FIRST);
   localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(OFS_SECOND);
   localparam logic [ADDR_W-1:0] A_QUERY  = ADDR_W'(OFS_QUERY);

   seq_mode_e mode_nxt;
   logic      byp_nxt;
   logic      at_first, at_second, at_query;

   assign at_first  = (addr == A_FIRST);
   assign at_second = (addr == A_SECOND);
   assign at_query  = (addr == A_QUERY);

   always_comb begin
      mode_nxt = mode;
      byp_nxt  = bypass;
      prog_en  = 1'b0;
      esec_en  = 1'b0;
      echip_en = 1'b0;
      if (mode == ST_ERASE) begin
         if (erase_done) mode_nxt = bypass ? ST_CMD : ST_READ;
      end else if (wr) begin
         if (cmd == CB_RESET && mode != ST_PROG) begin
            mode_nxt = ST_READ;
            byp_nxt  = 1'b0;
         end else begin
            unique case (mode)
               ST_READ, ST_ESET: begin
                  if (at_query && cmd == CB_QUERY) begin
                     mode_nxt = ST_QUERY;
                  end else if (at_first && cmd == CB_UNLOCK_A) begin
                     mode_nxt = (mode == ST_READ) ? ST_UNLK1 : ST_ESET1;
                  end else begin
                     mode_nxt = ST_READ;
                     byp_nxt  = 1'b0;
                  end
               end
               ST_UNLK1, ST_ESET1: begin
                  if (at_second && cmd == CB_UNLOCK_B) begin
                     mode_nxt = (mode == ST_UNLK1) ? ST_CMD : ST_ESET2;
                  end else begin
                     mode_nxt = ST_READ;
                     byp_nxt  = 1'b0;
                  end
               end
               ST_CMD: begin
                  if (!bypass && !at_first) begin
                     mode_nxt = ST_READ;
                     byp_nxt  = 1'b0;
                  end else begin
                     unique case (cmd)
                        CB_BYPASS:  byp_nxt  = 1'b1;
                        CB_ESETUP:  mode_nxt = ST_ESET;
                        CB_IDENT:   mode_nxt = ST_AUTO;
                        CB_PROGRAM: mode_nxt = ST_PROG;
                        default: begin
                           mode_nxt = ST_READ;
                           byp_nxt  = 1'b0;
                        end
                     endcase
                  end
               end
               ST_PROG: begin
                  prog_en  = 1'b1;
                  mode_nxt = bypass ? ST_CMD : ST_READ;
               end
               ST_ESET2: begin
                  if (cmd == CB_CHIP && at_first) begin
                     echip_en = 1'b1;
                     mode_nxt = ST_ERASE;
                  end else if (cmd == CB_SECTOR) begin
                     esec_en  = 1'b1;
                     mode_nxt = ST_ERASE;
                  end else begin
                     mode_nxt = ST_READ;
                     byp_nxt  = 1'b0;
                  end
               end
               ST_AUTO: begin
                  if (at_query && cmd == CB_QUERY) begin
                     mode_nxt = ST_QUERY;
                  end else begin
                     mode_nxt = ST_READ;
                     byp_nxt  = 1'b0;
                  end
               end
               default: begin
                  mode_nxt = ST_READ;
                  byp_nxt  = 1'b0;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= ST_READ;
         bypass <= 1'b0;
      end else begin
         mode   <= mode_nxt;
         bypass <= byp_nxt;
      end
   end

   // R8: a reset byte outside program data and erase lands in read mode
   assert_reset_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && cmd == CB_RESET && mode != ST_PROG && mode != ST_ERASE)
      |=> (mode == ST_READ && !bypass));

   // R11: bypass only starts from an accepted 0x20 command cycle
   assert_bypass_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bypass) |-> $past(mode == ST_CMD && wr && cmd == CB_BYPASS));

   // R7: the erase state is left only when the timer reports completion
   assert_erase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == ST_ERASE && !erase_done) |=> (mode == ST_ERASE));

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
   parameter int unsigned SECTOR_CYC = 40,
   parameter int unsigned CHIP_CYC   = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_sec,
   input  logic start_chip,
   input  logic status_rd,
   output logic busy,
   output logic done,
   output logic toggle
);

   localparam int unsigned CW = $clog2(CHIP_CYC + 1);

   if (SECTOR_CYC < 1) begin : g_bad_sec
      $error("SECTOR_CYC must be at least 1");
   end
   if (CHIP_CYC <= SECTOR_CYC) begin : g_bad_chip
      $error("CHIP_CYC must exceed SECTOR_CYC");
   end

   logic [CW-1:0] cnt;

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         toggle <= 1'b0;
      end else if (start_chip) begin
         busy   <= 1'b1;
         cnt    <= CW'(CHIP_CYC - 1);
         toggle <= 1'b0;
      end else if (start_sec) begin
         busy   <= 1'b1;
         cnt    <= CW'(SECTOR_CYC - 1);
         toggle <= 1'b0;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
         if (status_rd) toggle <= ~toggle;
      end
   end

   // R6: the toggle bit moves only while an erase runs
   assert_toggle_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_sec && !start_chip) |=> $stable(toggle));

   // R5: completion always ends the busy interval on the next edge
   assert_done_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_sec && !start_chip) |=> !busy);

endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int unsigned SECTORS      = 4,
   parameter int unsigned SECTOR_WORDS = 256,
   localparam int unsigned OW = $clog2(SECTOR_WORDS),
   localparam int unsigned SW = $clog2(SECTORS),
   localparam int unsigned AW = OW + SW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog,
   input  logic          esec,
   input  logic          echip,
   input  logic [AW-1:0] waddr,
   input  logic [15:0]   wdata,
   input  logic [AW-1:0] raddr,
   output logic [15:0]   rword
);

   if ((1 << OW) != SECTOR_WORDS || SECTOR_WORDS < 2) begin : g_bad_words
      $error("SECTOR_WORDS must be a power of two, at least 2");
   end
   if ((1 << SW) != SECTORS || SECTORS < 2) begin : g_bad_sectors
      $error("SECTORS must be a power of two, at least 2");
   end

   logic [OW-1:0] woff, roff;
   logic [SW-1:0] wsec, rsec;
   logic [15:0]   rd_lane [SECTORS];

   assign woff = waddr[OW-1:0];
   assign wsec = waddr[AW-1:OW];
   assign roff = raddr[OW-1:0];
   assign rsec = raddr[AW-1:OW];

   for (genvar g = 0; g < SECTORS; g++) begin : g_sector
      logic [15:0] bank [SECTOR_WORDS];
      logic        hit;

      assign hit = (wsec == SW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n || echip || (esec && hit)) begin
            for (int i = 0; i < SECTOR_WORDS; i++) bank[i] <= 16'hFFFF;
         end else if (prog && hit) begin
            bank[woff] <= bank[woff] & wdata;
         end
      end

      assign rd_lane[g] = bank[roff];
   end

   assign rword = rd_lane[rsec];

   // R3: program and the two erase kinds never coincide
   assert_single_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog, esec, echip}));

endmodule

// File: rtl/flash_query_rom.sv
module flash_query_rom #(
   parameter int unsigned SECTORS      = 4,
   parameter int unsigned SECTOR_WORDS = 256
) (
   input  logic [5:0] idx,
   output logic [7:0] qbyte
);

   localparam int unsigned BYTES     = SECTORS * SECTOR_WORDS * 2;
   localparam logic [7:0]  SIZE_CODE = 8'($clog2(BYTES));
   localparam int unsigned BLK_UNITS = (SECTOR_WORDS * 2) / 256;
   localparam int unsigned LAST_SEC  = SECTORS - 1;

   always_comb begin
      unique case (idx)
         6'h10: qbyte = 8'h51;
         6'h11: qbyte = 8'h52;
         6'h12: qbyte = 8'h59;
         6'h13: qbyte = 8'h02;
         6'h1B: qbyte = 8'h27;
         6'h1C: qbyte = 8'h36;
         6'h1F: qbyte = 8'h07;
         6'h20: qbyte = 8'h04;
         6'h21: qbyte = 8'h09;
         6'h22: qbyte = 8'h0C;
         6'h23: qbyte = 8'h01;
         6'h24: qbyte = 8'h04;
         6'h25: qbyte = 8'h0A;
         6'h26: qbyte = 8'h0D;
         6'h27: qbyte = SIZE_CODE;
         6'h28: qbyte = 8'h02;
         6'h2C: qbyte = 8'h01;
         6'h2D: qbyte = 8'(LAST_SEC);
         6'h2E: qbyte = 8'(LAST_SEC >> 8);
         6'h2F: qbyte = 8'(BLK_UNITS);
         6'h30: qbyte = 8'(BLK_UNITS >> 8);
         default: qbyte = 8'h00;
      endcase
   end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
   import flash_cmd_pkg::*;
#(
   parameter int unsigned SECTORS          = 4,
   parameter int unsigned SECTOR_WORDS     = 256,
   parameter int unsigned ADDR_W           = 11,
   parameter int unsigned SECTOR_ERASE_CYC = 40,
   parameter int unsigned CHIP_ERASE_CYC   = 120,
   parameter logic [15:0] MFR_ID           = 16'h0001,
   parameter logic [15:0] DEV_ID           = 16'h227E,
   parameter logic [15:0] EXT_ID0          = 16'h2222,
   parameter logic [15:0] EXT_ID1          = 16'h2201
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output logic [15:0]       rdata,
   output logic              busy
);

   localparam int unsigned AW = $clog2(SECTORS) + $clog2(SECTOR_WORDS);

   if (ADDR_W < CMD_AW || ADDR_W < AW) begin : g_bad_aw
      $error("ADDR_W too narrow for command offsets or array");
   end

   seq_mode_e   mode;
   logic        bypass, prog_en, esec_en, echip_en;
   logic        erase_done, toggle, wr, rd;
   logic [15:0] rword, id_word;
   logic [7:0]  qbyte;

   assign wr = cs && we;
   assign rd = cs && !we;

   flash_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .cmd(wdata[7:0]),
      .erase_done(erase_done), .mode(mode), .bypass(bypass),
      .prog_en(prog_en), .esec_en(esec_en), .echip_en(echip_en)
   );

   flash_busy_timer #(.SECTOR_CYC(SECTOR_ERASE_CYC), .CHIP_CYC(CHIP_ERASE_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_sec(esec_en), .start_chip(echip_en),
      .status_rd(rd && mode == ST_ERASE), .busy(busy), .done(erase_done),
      .toggle(toggle)
   );

   flash_array #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_arr (
      .clk(clk), .rst_n(rst_n), .prog(prog_en), .esec(esec_en), .echip(echip_en),
      .waddr(addr[AW-1:0]), .wdata(wdata), .raddr(addr[AW-1:0]), .rword(rword)
   );

   flash_query_rom #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_rom (
      .idx(addr[5:0]), .qbyte(qbyte)
   );

   always_comb begin
      unique case (addr)
         ADDR_W'(0):    id_word = MFR_ID;
         ADDR_W'(1):    id_word = DEV_ID;
         ADDR_W'(2):    id_word = 16'h0000;
         ADDR_W'('hE):  id_word = EXT_ID0;
         ADDR_W'('hF):  id_word = EXT_ID1;
         default:       id_word = rword;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         unique case (mode)
            ST_ERASE: rdata <= {9'h000, toggle, 6'h00};
            ST_AUTO:  rdata <= id_word;
            ST_QUERY: rdata <= (addr < ADDR_W'(QUERY_LEN)) ? {8'h00, qbyte} : 16'h0000;
            default:  rdata <= rword;
         endcase
      end
   end

   // R7: busy and the erase state of the sequencer agree in every cycle
   assert_busy_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (mode == ST_ERASE));

   // R12: read data holds when no read is sampled
   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));

endmodule

// File: tb/flash_cmd_engine_test.sv
module flash_cmd_engine_test;

   localparam int unsigned SEC_CYC  = 40;
   localparam int unsigned CHIP_CYC = 120;
   localparam int unsigned WORDS    = 1024;
   localparam int unsigned SWORDS   = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0;
   logic        we = 1'b0;
   logic [10:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        busy;

   logic [15:0] model [WORDS];
   int          errors = 0;
   int          checks = 0;
   int unsigned cyc = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   flash_cmd_engine #(
      .SECTOR_ERASE_CYC(SEC_CYC), .CHIP_ERASE_CYC(CHIP_CYC)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .busy(busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [10:0] a, input logic [15:0] d);
      @(negedge clk);
      cs = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [10:0] a, output logic [15:0] d);
      @(negedge clk);
      cs = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      cs = 1'b0;
      d = rdata;
   endtask

   task automatic unlock();
      wr(11'h555, 16'h00AA);
      wr(11'h2AA, 16'h0055);
   endtask

   task automatic program_word(input logic [10:0] a, input logic [15:0] d);
      unlock();
      wr(11'h555, 16'h00A0);
      wr(a, d);
      model[a[9:0]] = model[a[9:0]] & d;
   endtask

   task automatic chk_word(input string req, input logic [10:0] a);
      logic [15:0] v;
      rd(a, v);
      check(req, v, model[a[9:0]]);
   endtask

   task automatic chk_all(input string req);
      int bad = 0;
      logic [15:0] v;
      for (int i = 0; i < WORDS; i++) begin
         rd(11'(i), v);
         if (v !== model[i]) bad++;
      end
      check(req, bad, 0);
   endtask

   task automatic wait_idle(input string req, input int unsigned start, input int unsigned n);
      int guard = 0;
      while (busy === 1'b1 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      check(req, cyc - start, n);
   endtask

   // R1, R12
   task automatic t_reset();
      logic [15:0] v;
      check("R1 busy low after reset", busy, 1'b0);
      rd(11'h000, v);
      check("R1 erased word after reset", v, 16'hFFFF);
      program_word(11'h3FF, 16'h5A5A);
      rd(11'h3FF, v);
      @(negedge clk); addr = 11'h000;
      @(negedge clk);
      check("R12 rdata holds without read", rdata, 16'h5A5A);
   endtask

   // R2, R3
   task automatic t_program();
      program_word(11'h010, 16'h1234);
      chk_word("R3 first program", 11'h010);
      program_word(11'h010, 16'hFF00);
      chk_word("R3 program ANDs", 11'h010);
      program_word(11'h010, 16'hFFFF);
      check("R3 cannot set bits", model[10'h010], 16'h1200);
      chk_word("R3 bits stay cleared", 11'h010);
   endtask

   // R2
   task automatic t_abort();
      wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055);
      wr(11'h555, 16'h00A0); wr(11'h020, 16'h0000);
      chk_word("R2 bad second unlock aborts", 11'h020);
      unlock(); wr(11'h554, 16'h00A0); wr(11'h021, 16'h0000);
      chk_word("R2 command at wrong address aborts", 11'h021);
      unlock(); wr(11'h555, 16'h0077); wr(11'h022, 16'h0000);
      chk_word("R2 unknown command aborts", 11'h022);
   endtask

   // R8
   task automatic t_reset_byte();
      program_word(11'h030, 16'h00F0);
      chk_word("R8 0xF0 programmed as data", 11'h030);
      unlock(); wr(11'h555, 16'h00F0);
      wr(11'h555, 16'h00A0); wr(11'h031, 16'h0000);
      chk_word("R8 reset byte in command cycle", 11'h031);
   endtask

   // R9, R10, R8
   task automatic t_ident();
      logic [15:0] v;
      unlock(); wr(11'h555, 16'h0090);
      rd(11'h000, v); check("R9 manufacturer id", v, 16'h0001);
      rd(11'h001, v); check("R9 device id", v, 16'h227E);
      rd(11'h002, v); check("R9 protection word", v, 16'h0000);
      rd(11'h00E, v); check("R9 ext id 0", v, 16'h2222);
      rd(11'h00F, v); check("R9 ext id 1", v, 16'h2201);
      rd(11'h010, v); check("R9 other address is array", v, model[10'h010]);
      wr(11'h055, 16'h0098);
      rd(11'h011, v); check("R10 query from ident mode", v, 16'h0052);
      wr(11'h000, 16'h00F0);
      rd(11'h000, v); check("R8 reset leaves query mode", v, model[0]);
   endtask

   // R10
   task automatic t_query();
      logic [15:0] v;
      wr(11'h055, 16'h0098);
      rd(11'h010, v); check("R10 Q", v, 16'h0051);
      rd(11'h011, v); check("R10 R", v, 16'h0052);
      rd(11'h012, v); check("R10 Y", v, 16'h0059);
      rd(11'h013, v); check("R10 command set", v, 16'h0002);
      rd(11'h027, v); check("R10 size code", v, 16'h000B);
      rd(11'h02D, v); check("R10 sector count", v, 16'h0003);
      rd(11'h02F, v); check("R10 sector size", v, 16'h0002);
      rd(11'h031, v); check("R10 beyond table", v, 16'h0000);
      rd(11'h040, v); check("R10 far beyond table", v, 16'h0000);
      wr(11'h000, 16'h0000);
      rd(11'h010, v); check("R10 write exits query", v, model[10'h010]);
   endtask

   // R5, R6, R7
   task automatic t_sector_erase();
      logic [15:0] v;
      int unsigned start;
      program_word(11'h150, 16'h00FF);
      program_word(11'h250, 16'h0F0F);
      unlock(); wr(11'h555, 16'h0080); unlock();
      wr(11'h1A0, 16'h0030);
      start = cyc;
      check("R5 busy after sector erase", busy, 1'b1);
      rd(11'h000, v); check("R6 first status read", v, 16'h0000);
      rd(11'h000, v); check("R6 toggled status", v, 16'h0040);
      rd(11'h000, v); check("R6 toggled back", v, 16'h0000);
      wr(11'h555, 16'h00F0);
      unlock(); wr(11'h555, 16'h00A0); wr(11'h250, 16'h0000);
      wait_idle("R5 sector erase duration", start, SEC_CYC);
      for (int i = 0; i < SWORDS; i++) model[SWORDS + i] = 16'hFFFF;
      chk_word("R5 erased sector word", 11'h150);
      chk_word("R7 writes ignored while busy", 11'h250);
      program_word(11'h151, 16'h0001);
      chk_word("R7 back in read mode after erase", 11'h151);
   endtask

   // R11
   task automatic t_bypass();
      int unsigned start;
      unlock(); wr(11'h555, 16'h0020);
      wr(11'h123, 16'h00A0); wr(11'h005, 16'h0F0F);
      model[5] = model[5] & 16'h0F0F;
      wr(11'h007, 16'h00A0); wr(11'h006, 16'h3C3C);
      model[6] = model[6] & 16'h3C3C;
      chk_word("R11 bypass program 1", 11'h005);
      chk_word("R11 bypass program 2", 11'h006);
      wr(11'h000, 16'h0080); unlock(); wr(11'h000, 16'h0030);
      start = cyc;
      wait_idle("R11 bypass sector erase duration", start, SEC_CYC);
      for (int i = 0; i < SWORDS; i++) model[i] = 16'hFFFF;
      wr(11'h000, 16'h00A0); wr(11'h008, 16'h1111);
      model[8] = 16'h1111;
      chk_word("R7 R11 erase returns to bypass", 11'h008);
      wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
      wr(11'h123, 16'h00A0); wr(11'h009, 16'h0000);
      chk_word("R11 exit leaves bypass", 11'h009);
   endtask

   // R4
   task automatic t_chip_erase();
      int unsigned start;
      unlock(); wr(11'h555, 16'h0080); unlock(); wr(11'h100, 16'h0010);
      check("R4 chip erase at wrong address aborts", busy, 1'b0);
      chk_word("R4 no erase on abort", 11'h250);
      unlock(); wr(11'h555, 16'h0080); unlock(); wr(11'h555, 16'h0010);
      start = cyc;
      wait_idle("R4 chip erase duration", start, CHIP_CYC);
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
      chk_all("R4 whole array erased");
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_abort();
      t_reset_byte();
      t_ident();
      t_query();
      t_sector_erase();
      t_bypass();
      t_chip_erase();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule